// File: doc/BRIEF.md
# Overflow-Tracking Vector Integer Adder

This block adds or subtracts two vectors of 32-bit integer elements and carries overflow information alongside the data. Elements are grouped in pairs. The lower element of each pair (even index) holds a data value. The upper element (odd index) holds a small status word that records whether that value has ever overflowed. The status word is sticky. Every operation ORs the status of both operands into the result, and then adds any overflow raised by the current operation. A long chain of vector operations can therefore run without any trap or global flag, and overflow is checked once, on the final result.

A select input chooses addition or subtraction. A second select chooses signed or unsigned interpretation, and it controls which new overflow condition is recorded. Data lanes always hold the wrapped two's-complement result. The result vector is registered, with one cycle of latency, and a new operation can be issued on every clock.

Top module: `ovt_vec_adder`

## Requirements
- R1: Each even lane of the result holds the low 32 bits of a+b when op_sub is 0, and of a-b when op_sub is 1, using the matching even lanes of opa and opb. An overflowing result wraps.
- R2: With sign_mode=1, bit 0 of the odd lane is set when the signed result of the current operation falls outside [-2^31, 2^31-1].
- R3: With sign_mode=0, bit 1 of the odd lane is set when the unsigned operation leaves [0, 2^32-1]. For addition this is a carry out. For subtraction it is a borrow, meaning a < b.
- R4: Bit 0 and bit 1 of each result odd lane are also set whenever the same bit is set in the odd lane of opa or of opb, whatever the mode and operation.
- R5: The condition that the mode does not select adds nothing. In signed mode an unsigned carry or borrow leaves bit 1 clear unless an input had it set. In unsigned mode a signed overflow leaves bit 0 clear unless an input had it set.
- R6: Bits 31:2 of every result odd lane are zero. Bits 31:2 of the input odd lanes have no effect on any output.
- R7: The result appears at the output one clock after its inputs are sampled, and a new operation can be accepted every cycle. While rst_n is low the result is all zeros.
- R8: Each pair is computed only from its own operand pair. Overflow in one pair does not change any other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sub | input | 1 | 0 selects add, 1 selects subtract (opa - opb) |
| sign_mode | input | 1 | 1 records signed overflow, 0 records unsigned carry/borrow |
| opa | input | LANES*32 | First operand vector; lane i at bits [32*i +: 32] |
| opb | input | LANES*32 | Second operand vector, same layout |
| result | output | LANES*32 | Registered result vector: data in even lanes, status in odd lanes |

## Verification
The assertions check every cycle that each data lane equals the wrapped sum or difference of the inputs from one cycle earlier. They also check that a flag present on either input is never lost, and that the unselected overflow kind is never newly raised. Some behaviour only the scoreboard scenarios can show: the exact signed and unsigned boundaries (0x7FFFFFFF+1, 0x80000000-1, 0xFFFFFFFF+1, 0-1), the fact that odd-lane garbage in the upper bits is ignored, pair independence under mixed vectors, and the reset value. Back-to-back issue with no gaps shows the one-cycle throughput.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int unsigned ELEM_W   = 32;
  localparam int unsigned ST_SOVF  = 0;  // signed overflow flag position
  localparam int unsigned ST_UCARY = 1;  // unsigned carry/borrow flag position
  localparam int unsigned ST_BITS  = 2;

  typedef struct packed {
    logic ucary;
    logic sovf;
  } ovt_stat_t;
endpackage

// File: rtl/ovt_lane_arith.sv
module ovt_lane_arith
  import ovt_pkg::*;
#(
  parameter int unsigned W = ELEM_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] value,
  output logic         sovf,
  output logic         uflag
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic         cout;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    value = wide[W-1:0];
    cout  = wide[W];
    // borrow is the inverse of the carry out when subtracting
    uflag = sub ? ~cout : cout;
    sovf  = (a[W-1] == b_eff[W-1]) && (value[W-1] != a[W-1]);
  end
endmodule

// File: rtl/ovt_flag_merge.sv
module ovt_flag_merge
  import ovt_pkg::*;
#(
  parameter int unsigned W = ELEM_W
) (
  input  ovt_stat_t    stat_a,
  input  ovt_stat_t    stat_b,
  input  logic         sovf,
  input  logic         uflag,
  input  logic         sign_mode,
  output logic [W-1:0] stat_word
);
  ovt_stat_t merged;

  always_comb begin
    merged.sovf  = stat_a.sovf  | stat_b.sovf  | (sign_mode  & sovf);
    merged.ucary = stat_a.ucary | stat_b.ucary | (!sign_mode & uflag);
    stat_word           = '0;
    stat_word[ST_SOVF]  = merged.sovf;
    stat_word[ST_UCARY] = merged.ucary;
  end
endmodule

// File: rtl/ovt_vec_adder.sv
module ovt_vec_adder
  import ovt_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_sub,
  input  logic                      sign_mode,
  input  logic [LANES*ELEM_W-1:0]   opa,
  input  logic [LANES*ELEM_W-1:0]   opb,
  output logic [LANES*ELEM_W-1:0]   result
);
  localparam int unsigned PAIRS = LANES / 2;
  localparam int unsigned VW    = LANES * ELEM_W;

  logic [VW-1:0] res_d;
  logic [VW-1:0] res_q;
  logic          past_ok;
  logic [PAIRS*(ELEM_W-ST_BITS)*2-1:0] unused_hi;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int unsigned EV = 2*p*ELEM_W;
    localparam int unsigned OD = EV + ELEM_W;

    logic       sovf;
    logic       uflag;
    ovt_stat_t  sa;
    ovt_stat_t  sb;

    assign sa = ovt_stat_t'(opa[OD +: ST_BITS]);
    assign sb = ovt_stat_t'(opb[OD +: ST_BITS]);
    assign unused_hi[p*2*(ELEM_W-ST_BITS) +: 2*(ELEM_W-ST_BITS)] =
      {opa[OD+ST_BITS +: ELEM_W-ST_BITS], opb[OD+ST_BITS +: ELEM_W-ST_BITS]};

    ovt_lane_arith #(.W(ELEM_W)) u_arith (
      .a     (opa[EV +: ELEM_W]),
      .b     (opb[EV +: ELEM_W]),
      .sub   (op_sub),
      .value (res_d[EV +: ELEM_W]),
      .sovf  (sovf),
      .uflag (uflag)
    );

    ovt_flag_merge #(.W(ELEM_W)) u_merge (
      .stat_a    (sa),
      .stat_b    (sb),
      .sovf      (sovf),
      .uflag     (uflag),
      .sign_mode (sign_mode),
      .stat_word (res_d[OD +: ELEM_W])
    );

    AST_DATA_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> result[EV +: ELEM_W] ==
        ($past(op_sub) ? $past(opa[EV +: ELEM_W]) - $past(opb[EV +: ELEM_W])
                       : $past(opa[EV +: ELEM_W]) + $past(opb[EV +: ELEM_W]))); // R1
    AST_KEEP_SOVF: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(opa[OD+ST_SOVF] | opb[OD+ST_SOVF])) |-> result[OD+ST_SOVF]); // R4
    AST_KEEP_UCARY: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(opa[OD+ST_UCARY] | opb[OD+ST_UCARY])) |-> result[OD+ST_UCARY]); // R4
    AST_NO_NEW_UCARY: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(sign_mode) && !$past(opa[OD+ST_UCARY] | opb[OD+ST_UCARY]))
        |-> !result[OD+ST_UCARY]); // R5
    AST_NO_NEW_SOVF: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(sign_mode) && !$past(opa[OD+ST_SOVF] | opb[OD+ST_SOVF]))
        |-> !result[OD+ST_SOVF]); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      res_q   <= res_d;
      past_ok <= 1'b1;
    end
  end

  assign result = res_q;
endmodule

// File: tb/sim_ovt_vec_adder.sv
module sim_ovt_vec_adder;
  localparam int LANES = 8;
  localparam int W     = 32;
  localparam int VW    = LANES * W;

  logic          clk;
  logic          rst_n;
  logic          op_sub;
  logic          sign_mode;
  logic [VW-1:0] opa;
  logic [VW-1:0] opb;
  logic [VW-1:0] result;

  typedef struct {
    logic [VW-1:0] exp;
    longint        due;
    string         tag;
  } item_t;

  item_t  sbq[$];
  longint cyc;
  int     n_run;
  int     n_fail;
  bit     done;

  ovt_vec_adder #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .sign_mode(sign_mode),
    .opa(opa), .opb(opb), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // reference from the requirements: exact integer arithmetic in 64 bits
  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                          logic sub, logic sgn);
    logic [VW-1:0] r = '0;
    for (int p = 0; p < LANES/2; p++) begin
      longint sa, sb, sr, ua, ub, ur;
      logic so, uo;
      sa = longint'($signed(a[2*p*W +: W]));
      sb = longint'($signed(b[2*p*W +: W]));
      ua = longint'({32'd0, a[2*p*W +: W]});
      ub = longint'({32'd0, b[2*p*W +: W]});
      sr = sub ? sa - sb : sa + sb;
      ur = sub ? ua - ub : ua + ub;
      so = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      uo = (ur > 64'sd4294967295) || (ur < 0);
      r[2*p*W +: W]     = ur[31:0];
      r[(2*p+1)*W + 0]  = a[(2*p+1)*W + 0] | b[(2*p+1)*W + 0] | (sgn & so);
      r[(2*p+1)*W + 1]  = a[(2*p+1)*W + 1] | b[(2*p+1)*W + 1] | (!sgn & uo);
    end
    return r;
  endfunction

  task automatic drive(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic sub, input logic sgn, input string tag);
    item_t it;
    @(negedge clk);
    opa = a; opb = b; op_sub = sub; sign_mode = sgn;
    it.exp = model(a, b, sub, sgn);
    it.due = cyc + 1;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare each result once its sampling edge has passed
  always @(negedge clk) begin
    if (rst_n && sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      n_run++;
      if (result !== it.exp) begin
        n_fail++;
        for (int l = 0; l < LANES; l++)
          if (result[l*W +: W] !== it.exp[l*W +: W])
            $display("FAIL %s lane %0d: got %h expected %h", it.tag, l,
                     result[l*W +: W], it.exp[l*W +: W]);
      end
    end
  end

  function automatic logic [VW-1:0] pairs(logic [W-1:0] v, logic [W-1:0] s);
    logic [VW-1:0] r;
    for (int p = 0; p < LANES/2; p++) r[2*p*W +: 2*W] = {s, v};
    return r;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [VW-1:0] a, b;
    cyc = 0; n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; op_sub = 0; sign_mode = 0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;  // R7 reset value
    if (result !== '0) begin
      n_fail++;
      $display("FAIL R7 reset: got %h expected 0", result);
    end
    rst_n = 1'b1;

    drive(pairs(32'd100, 0), pairs(32'd23, 0), 0, 1, "R1 add");
    drive(pairs(32'd5, 0), pairs(32'd9, 0), 1, 1, "R1 sub wrap");
    drive(pairs(32'h7FFFFFFF, 0), pairs(32'd1, 0), 0, 1, "R2 signed add ovf");
    drive(pairs(32'h80000000, 0), pairs(32'd1, 0), 1, 1, "R2 signed sub ovf");
    drive(pairs(32'h7FFFFFFE, 0), pairs(32'd1, 0), 0, 1, "R2 signed edge no ovf");
    drive(pairs(32'hFFFFFFFF, 0), pairs(32'd1, 0), 0, 0, "R3 carry");
    drive(pairs(32'd0, 0), pairs(32'd1, 0), 1, 0, "R3 borrow");
    drive(pairs(32'd7, 0), pairs(32'd7, 0), 1, 0, "R3 equal no borrow");
    drive(pairs(32'd1, 32'd1), pairs(32'd2, 32'd2), 0, 0, "R4 sticky in unsigned");
    drive(pairs(32'd1, 32'd2), pairs(32'd2, 32'd1), 1, 1, "R4 sticky in signed");
    drive(pairs(32'hFFFFFFFF, 0), pairs(32'd1, 0), 0, 1, "R5 carry ignored signed");
    drive(pairs(32'h7FFFFFFF, 0), pairs(32'd1, 0), 0, 0, "R5 sovf ignored unsigned");
    drive(pairs(32'd3, 32'hDEADBEEC), pairs(32'd4, 32'hFFFFFFFC), 0, 1, "R6 upper bits ignored");
    a = '0; b = '0;  // R8 mixed pairs
    a[0*W +: W] = 32'hFFFFFFFF; b[0*W +: W] = 32'd1;
    a[2*W +: W] = 32'd10;       b[2*W +: W] = 32'd20;
    a[4*W +: W] = 32'h7FFFFFFF; b[4*W +: W] = 32'h7FFFFFFF;
    a[7*W +: W] = 32'd2;
    drive(a, b, 0, 0, "R8 pair independence");
    drive(a, b, 0, 1, "R8 pair independence signed");
    for (int i = 0; i < 300; i++) begin  // R7 back-to-back issue
      for (int l = 0; l < LANES; l++) begin
        a[l*W +: W] = $urandom;
        b[l*W +: W] = $urandom;
      end
      drive(a, b, 1'($urandom), 1'($urandom), "R7 random stream");
    end
    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end
endmodule